// File: doc/BRIEF.md
# Logic-Instruction Execute Unit

This unit decodes and executes the bitwise-logic group of a 32-bit RISC machine whose instructions are 16 bits wide. It owns a bank of sixteen 32-bit general registers and a global base register. It covers AND, OR, XOR and test (TST) in three addressing forms: register with register, R0 with an 8-bit immediate, and a byte in memory at R0 plus the base register. It also executes NOT and a byte test-and-set. Test operations update a single status flag T. No other operation in the group changes T.

An upstream stage presents one instruction word with `ins_valid` and holds it until `ins_ready` is high at a rising edge. Register and immediate forms finish in the cycle they are presented. Byte forms and test-and-set run a three-cycle read-modify-write on a byte-wide memory port whose read data arrives one cycle after the read strobe. Registers and the base register are loaded, and any register read back, through a side port that is used while the unit is not writing a register.

Top module: `logic_xu`

## Requirements
- R1: While reset is held and after it is released, T is 0, `ins_ready` is 1 when idle, and neither memory strobe is active.
- R2: Words of the form 0010 nnnn mmmm 10oo perform Rn op Rm, where oo is 01 AND, 10 XOR, 11 OR, and write the result into Rn in one cycle.
- R3: Word 0110 nnnn mmmm 0111 writes the bitwise complement of Rm into Rn in one cycle.
- R4: Words 11001 0oo iiiiiiii combine R0 with the immediate, zero-extended to 32 bits, using oo (01 AND, 10 XOR, 11 OR), and write R0 in one cycle.
- R5: TST, which is oo = 00 in the register and immediate forms, sets T to 1 when the AND of its operands is zero and to 0 otherwise, writes no register, and takes one cycle.
- R6: Words 11001 1oo iiiiiiii with oo = 01, 10 or 11 read the byte at address R0+base, apply the operation with the immediate, and write the result back to the same address. This takes three cycles: read strobe, capture, then write strobe. `ins_ready` is low for the first two cycles.
- R7: Byte TST (1100 1100 iiiiiiii) reads the byte, sets T from the AND with the immediate, issues no write, and still takes three cycles.
- R8: Word 0100 nnnn 0001 1011 reads the byte at address Rn, sets T to 1 if the byte is zero and to 0 otherwise, and writes the byte back with bit 7 set. This takes three cycles.
- R9: AND, OR, XOR and NOT in every form leave T unchanged.
- R10: Any other word raises `illegal` for its single cycle and changes no register, no memory byte and not T.
- R11: The load port writes a register or the base register at a clock edge, and the read-back port returns the addressed register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 16 | Instruction word, held until accepted |
| ins_ready | output | 1 | Instruction completes at this edge |
| illegal | output | 1 | Undecodable word presented |
| t_flag | output | 1 | Test status flag |
| ld_we | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register load index |
| ld_data | input | XLEN | Register load value |
| gbr_ld | input | 1 | Base register load strobe |
| gbr_data | input | XLEN | Base register load value |
| dbg_idx | input | 4 | Read-back register index |
| dbg_data | output | XLEN | Read-back register value |
| mem_addr | output | XLEN | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The hardest case to reach is a test-and-set or byte TST whose outcome depends on the memory contents, not on the registers. It must be shown that the unit samples the returned byte in the capture cycle, and that TST leaves the byte untouched. The stimulus points the base register and R0 at a byte known to be zero. It runs OR, AND and XOR on that byte so that its value changes in known steps, and then tests it with masks that give both values of T. A second byte that starts at zero is hit twice with test-and-set, so that the first pass sets T and the second clears it.

// File: rtl/logic_xu_pkg.sv
package logic_xu_pkg;
  localparam int IW    = 16;
  localparam int NREG  = 16;
  localparam int RIDX  = $clog2(NREG);
  localparam int BYTEW = 8;

  typedef enum logic [2:0] {K_NONE, K_REG, K_NOT, K_IMM, K_BYTE, K_TAS} kind_e;
  typedef enum logic [1:0] {OP_TST = 2'b00, OP_AND = 2'b01, OP_XOR = 2'b10, OP_OR = 2'b11} lop_e;
  typedef enum logic [1:0] {S_IDLE, S_CAP, S_WR} seq_e;

  typedef struct packed {
    kind_e            kind;
    lop_e             op;
    logic [RIDX-1:0]  rn;
    logic [RIDX-1:0]  rm;
    logic [BYTEW-1:0] imm;
  } dec_t;
endpackage

// File: rtl/logic_xu_decode.sv
module logic_xu_decode
  import logic_xu_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    dec.op   = lop_e'(word[1:0]);
    dec.rn   = word[11:8];
    dec.rm   = word[7:4];
    dec.imm  = word[7:0];
    if (word[15:12] == 4'b0010 && word[3:2] == 2'b10) begin
      dec.kind = K_REG;
    end else if (word[15:12] == 4'b0110 && word[3:0] == 4'b0111) begin
      dec.kind = K_NOT;
    end else if (word[15:11] == 5'b11001) begin
      dec.op   = lop_e'(word[9:8]);
      dec.rn   = '0;
      dec.kind = word[10] ? K_BYTE : K_IMM;
    end else if (word[15:12] == 4'b0100 && word[7:0] == 8'h1B) begin
      dec.kind = K_TAS;
    end
  end
endmodule

// File: rtl/logic_xu_regfile.sv
module logic_xu_regfile
  import logic_xu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [RIDX-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [RIDX-1:0] rc_idx,
  output logic [XLEN-1:0] rc_data,
  input  logic            base_we,
  input  logic [XLEN-1:0] base_wdata,
  output logic [XLEN-1:0] base_q
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (base_we) base_q <= base_wdata;
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rc_data = regs[rc_idx];
endmodule

// File: rtl/logic_xu_alu.sv
module logic_xu_alu
  import logic_xu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  lop_e            op,
  input  logic            invert,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            zero
);
  always_comb begin
    if (invert) begin
      res = ~b;
    end else begin
      unique case (op)
        OP_OR:   res = a | b;
        OP_XOR:  res = a ^ b;
        default: res = a & b;
      endcase
    end
  end

  assign zero = ~|(a & b);
endmodule

// File: rtl/logic_xu.sv
module logic_xu
  import logic_xu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [IW-1:0]     ins_word,
  output logic              ins_ready,
  output logic              illegal,
  output logic              t_flag,
  input  logic              ld_we,
  input  logic [RIDX-1:0]   ld_idx,
  input  logic [XLEN-1:0]   ld_data,
  input  logic              gbr_ld,
  input  logic [XLEN-1:0]   gbr_data,
  input  logic [RIDX-1:0]   dbg_idx,
  output logic [XLEN-1:0]   dbg_data,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_rd,
  input  logic [BYTEW-1:0]  mem_rdata,
  output logic              mem_wr,
  output logic [BYTEW-1:0]  mem_wdata
);
  localparam int PADW = XLEN - BYTEW;

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dec_t dec;
  logic_xu_decode u_dec (.word(ins_word), .dec(dec));

  logic [XLEN-1:0] rn_val, rm_val, base_val, alu_a, alu_b, alu_res;
  logic            alu_zero, exec_we;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  assign rf_we    = exec_we | ld_we;
  assign rf_waddr = exec_we ? dec.rn  : ld_idx;
  assign rf_wdata = exec_we ? alu_res : ld_data;

  logic_xu_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_idx(dec.rn), .ra_data(rn_val),
    .rb_idx(dec.rm), .rb_data(rm_val),
    .rc_idx(dbg_idx), .rc_data(dbg_data),
    .base_we(gbr_ld), .base_wdata(gbr_data), .base_q(base_val)
  );

  seq_e             st_q, st_d;
  logic             t_q, t_d;
  logic [BYTEW-1:0] rd_q;

  assign alu_a = (dec.kind == K_BYTE) ? {{PADW{1'b0}}, rd_q} : rn_val;
  assign alu_b = (dec.kind == K_IMM || dec.kind == K_BYTE) ? {{PADW{1'b0}}, dec.imm} : rm_val;

  logic_xu_alu #(.XLEN(XLEN)) u_alu (
    .op(dec.op), .invert(dec.kind == K_NOT), .a(alu_a), .b(alu_b),
    .res(alu_res), .zero(alu_zero)
  );

  assign mem_addr = (dec.kind == K_TAS) ? rn_val : rn_val + base_val;
  assign t_flag   = t_q;

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    t_d       = t_q;
    ins_ready = 1'b0;
    illegal   = 1'b0;
    exec_we   = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = alu_res[BYTEW-1:0];
    unique case (st_q)
      S_IDLE: begin
        ins_ready = 1'b1;
        if (ins_valid) begin
          unique case (dec.kind)
            K_REG, K_NOT, K_IMM: begin
              if (dec.kind != K_NOT && dec.op == OP_TST) t_d = alu_zero;
              else                                       exec_we = 1'b1;
            end
            K_BYTE, K_TAS: begin
              ins_ready = 1'b0;
              mem_rd    = 1'b1;
              st_d      = S_CAP;
            end
            default: illegal = 1'b1;
          endcase
        end
      end
      S_CAP: st_d = S_WR;
      default: begin
        ins_ready = 1'b1;
        if (ins_valid) begin
          st_d = S_IDLE;
          if (dec.kind == K_TAS) begin
            mem_wr    = 1'b1;
            mem_wdata = rd_q | 8'h80;
            t_d       = (rd_q == '0);
          end else if (dec.op == OP_TST) begin
            t_d = alu_zero;
          end else begin
            mem_wr = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q <= S_IDLE;
      t_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      t_q  <= t_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_CAP) rd_q <= mem_rdata;
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_rd && mem_wr));
  p_read_stalls_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd |=> (!ins_ready && !mem_rd && !mem_wr));
  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |-> $past(mem_rd, 2));
  p_byte_tst_no_write_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |-> (ins_word[15:8] != 8'hCC));
  p_t_kept_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ins_valid && ins_ready && dec.kind != K_TAS && !(dec.kind != K_NOT && dec.op == OP_TST))
      |=> $stable(t_flag));
  p_illegal_single_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    illegal |-> (ins_ready && !mem_rd && !mem_wr));
endmodule

// File: tb/logic_xu_tb.sv
module logic_xu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid;
  logic [15:0] ins_word;
  logic        ins_ready, illegal, t_flag;
  logic        ld_we;
  logic [3:0]  ld_idx;
  logic [31:0] ld_data;
  logic        gbr_ld;
  logic [31:0] gbr_data;
  logic [3:0]  dbg_idx;
  logic [31:0] dbg_data;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata, mem_wdata;

  always #2 clk = ~clk;

  logic_xu u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_ready(ins_ready), .illegal(illegal), .t_flag(t_flag),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .gbr_ld(gbr_ld), .gbr_data(gbr_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  // byte memory, read data one cycle after the strobe
  logic [7:0] mem [256];
  int         wr_count = 0;
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  // reference state
  logic [31:0] exp_r [16];
  logic [31:0] exp_gbr;
  logic [7:0]  exp_mem [256];
  logic        exp_t;
  bit          live = 1'b0;
  int          checks = 0;
  int          fails  = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) check("R9", "T per clock", {31'b0, t_flag}, {31'b0, exp_t});
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  task automatic load(input int idx, input logic [31:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = 4'(idx); ld_data = v;
    @(posedge clk);
    exp_r[idx] = v;
    @(negedge clk);
    ld_we = 1'b0;
    dbg_idx = 4'(idx);
    #1 check("R11", "load readback", dbg_data, v);
  endtask

  task automatic load_base(input logic [31:0] v);
    @(negedge clk);
    gbr_ld = 1'b1; gbr_data = v;
    @(posedge clk);
    exp_gbr = v;
    @(negedge clk);
    gbr_ld = 1'b0;
  endtask

  task automatic run(input logic [15:0] w, input string tag);
    int          n, m, ec, cyc;
    bit          eill, wreg, wmem;
    logic        nt, ill;
    logic [31:0] imm, v;
    logic [7:0]  ma, mb;
    n = int'(w[11:8]); m = int'(w[7:4]); imm = {24'b0, w[7:0]};
    ec = 1; eill = 0; wreg = 0; wmem = 0; nt = exp_t; v = '0; mb = '0;
    ma = 8'(exp_r[0] + exp_gbr);
    casez (w)
      16'b0010_????_????_1000: nt = ((exp_r[n] & exp_r[m]) == 0);
      16'b0010_????_????_1001: begin wreg = 1; v = exp_r[n] & exp_r[m]; end
      16'b0010_????_????_1010: begin wreg = 1; v = exp_r[n] ^ exp_r[m]; end
      16'b0010_????_????_1011: begin wreg = 1; v = exp_r[n] | exp_r[m]; end
      16'b0110_????_????_0111: begin wreg = 1; v = ~exp_r[m]; end
      16'b1100_1000_????_????: begin n = 0; nt = ((exp_r[0] & imm) == 0); end
      16'b1100_1001_????_????: begin n = 0; wreg = 1; v = exp_r[0] & imm; end
      16'b1100_1010_????_????: begin n = 0; wreg = 1; v = exp_r[0] ^ imm; end
      16'b1100_1011_????_????: begin n = 0; wreg = 1; v = exp_r[0] | imm; end
      16'b1100_1100_????_????: begin ec = 3; nt = ((exp_mem[ma] & w[7:0]) == 0); end
      16'b1100_1101_????_????: begin ec = 3; wmem = 1; mb = exp_mem[ma] & w[7:0]; end
      16'b1100_1110_????_????: begin ec = 3; wmem = 1; mb = exp_mem[ma] ^ w[7:0]; end
      16'b1100_1111_????_????: begin ec = 3; wmem = 1; mb = exp_mem[ma] | w[7:0]; end
      16'b0100_????_0001_1011: begin
        ec = 3; ma = exp_r[n][7:0]; nt = (exp_mem[ma] == 0);
        wmem = 1; mb = exp_mem[ma] | 8'h80;
      end
      default: eill = 1;
    endcase
    @(negedge clk);
    ins_word = w; ins_valid = 1'b1;
    #1 cyc = 1;
    while (!ins_ready && cyc < 8) begin
      @(negedge clk); #1 cyc++;
    end
    ill = illegal;
    @(posedge clk);
    exp_t = nt;
    if (wreg) exp_r[n] = v;
    if (wmem) exp_mem[ma] = mb;
    @(negedge clk);
    ins_valid = 1'b0;
    dbg_idx = 4'(n);
    #1;
    check(tag, "cycles", 32'(cyc), 32'(ec));
    check(eill ? "R10" : tag, "illegal flag", {31'b0, ill}, {31'b0, eill});
    check(tag, "register", dbg_data, exp_r[n]);
    check(tag, "memory byte", {24'b0, mem[ma]}, {24'b0, exp_mem[ma]});
    check(tag, "T", {31'b0, t_flag}, {31'b0, exp_t});
    if (eill) check("R10", "illegal drops", {31'b0, illegal}, 32'b0);
  endtask

  initial begin
    int wc;
    rst_n = 1'b0; ins_valid = 1'b0; ins_word = '0; ld_we = 1'b0; ld_idx = '0;
    ld_data = '0; gbr_ld = 1'b0; gbr_data = '0; dbg_idx = '0; exp_t = 1'b0; exp_gbr = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    mem[8'h40] = 8'h00; exp_mem[8'h40] = 8'h00;
    mem[8'h50] = 8'h00; exp_mem[8'h50] = 8'h00;
    for (int i = 0; i < 16; i++) exp_r[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "T in reset", {31'b0, t_flag}, 32'b0);
    check("R1", "read strobe in reset", {31'b0, mem_rd}, 32'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "T after reset", {31'b0, t_flag}, 32'b0);
    check("R1", "ready idle", {31'b0, ins_ready}, 32'b1);
    check("R1", "write strobe idle", {31'b0, mem_wr}, 32'b0);
    for (int i = 0; i < 16; i++) load(i, 32'h1111_0000 * 32'(i) + 32'(i));
    live = 1'b1;
    load(1, 32'hF0F0_1234); load(2, 32'h0FF0_00FF); load(7, 32'hAAAA_5555);
    load(9, 32'h0000_000F); load(10, 32'h0000_00F0);
    run(16'h2129, "R2");          // AND R1,R2
    run(16'h231B, "R2");          // OR R3,R1
    run(16'h271A, "R2");          // XOR R7,R1
    run(16'h6817, "R3");          // NOT R8,R1
    run(16'h29A8, "R5");          // TST zero result
    run(16'h2129, "R9");          // AND keeps T=1
    run(16'h6817, "R9");          // NOT keeps T=1
    run(16'h2118, "R5");          // TST nonzero
    load(0, 32'hFFFF_FF5A);
    run(16'hC9FF, "R4");          // AND imm, zero extension
    run(16'hCB81, "R4");
    run(16'hCA0F, "R4");
    run(16'hC800, "R5");
    run(16'hC801, "R5");
    load(0, 32'h0000_0010); load_base(32'h0000_0030); load(6, 32'h40); load(11, 32'h50);
    run(16'hCF81, "R6");          // OR.B  -> 81
    run(16'hCD0F, "R6");          // AND.B -> 01
    run(16'hCEFF, "R6");          // XOR.B -> FE
    run(16'hC8FF, "R9");          // T from R0 test
    wc = wr_count;
    run(16'hCC01, "R7");          // byte test, zero
    run(16'hCC02, "R7");          // byte test, nonzero
    check("R7", "no write issued", 32'(wr_count), 32'(wc));
    run(16'h4B1B, "R8");          // zero byte
    run(16'h4B1B, "R8");          // now 0x80
    run(16'h461B, "R8");
    run(16'hFFFF, "R10");
    run(16'h2184, "R10");
    run(16'h6818, "R10");
    run(16'h4B1C, "R10");
    live = 1'b0;
    finish_run();
  end
endmodule